// File: doc/BRIEF.md
# Pin Control Register Bank

This block keeps one 32-bit configuration word for each of 32 pins. Each word selects the pin's pull, pull strength, slew, passive filter, open drain, drive strength, function mux, input buffer, input inversion and a lock bit, plus a 4-bit interrupt condition code. A simple single-cycle register bus reaches every pin word directly. Four broadcast addresses configure many pins in one access, and a mux-only window changes a single pin's function select without touching its other fields. The decoded fields leave the bank as flat per-pin vectors that drive the pad cells and the function multiplexers.

Writes take effect on the rising clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Setting the lock bit freezes the lower half of that pin's word until the next reset. The interrupt code stays writable.

Word layout: [1:0] pull select, [2] strong pull, [3] slow slew, [4] passive filter, [5] open drain, [6] high drive, [8 +: MUX_W] mux, [12] input buffer enable, [13] input invert, [15] lock, [19:16] interrupt condition. All other bits read 0.

Address map (word addresses, ADDR_W = 7): pins 0..31 at 0..31. Broadcast lower-half writes for pins 0..15 at 32 and for pins 16..31 at 33. Broadcast interrupt writes for pins 0..15 at 34 and for pins 16..31 at 35. The mux-only window for pin p is at 64+p.

Top module: `pcr_bank`

## Requirements
- R1: After reset every pin word reads 0 and every pad output is 0.
- R2: A write to pin address p stores wdata[15:0] masked to the defined lower fields, plus wdata[19:16] as the interrupt code. Reading p returns these fields with all undefined bits 0, so writing 0xFFF07FFF to an unlocked pin reads back 0x00003F7F.
- R3: The pull select decodes as follows: 0 gives no pull, 2 gives pull-down, 3 gives pull-up, and the unused code 1 gives no pull. `pad_pull_en` follows bit 1 of the select, and `pad_pull_up` is high only for code 3.
- R4: Each remaining pad output equals its stored field for that pin. This covers strong pull, slew, filter, open drain, drive, mux (pin p at bits p*MUX_W), input buffer, invert, lock, and the interrupt code (pin p at bits p*4).
- R5: While a pin's lock bit (bit 15) is 1, writes leave bits 15:0 of that pin unchanged, but its interrupt code still accepts writes.
- R6: A write to address 32 loads wdata[15:0] as the lower half of each pin i in 0..15 whose wdata[16+i] is 1. Other pins and all interrupt codes stay unchanged.
- R7: A write to address 33 does the same for pin 16+i, selected by wdata[16+i].
- R8: A write to address 34 or 35 loads wdata[19:16] into the interrupt code of each pin i (0..15) or 16+i whose wdata[i] is 1. Lower halves stay unchanged, and a zero mask changes nothing.
- R9: A write to address 64+p loads wdata[8 +: MUX_W] into pin p's mux field only. Every other field is kept.
- R10: Broadcast lower-half writes and mux-only writes skip locked pins.
- R11: Broadcast addresses and unmapped addresses read 0, and writes to unmapped addresses change nothing.
- R12: The lock bit clears only on reset. After reset the pin accepts lower-half writes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_pull_en | output | NPINS | Pull resistor enabled per pin |
| pad_pull_up | output | NPINS | Pull direction is up per pin |
| pad_pull_strong | output | NPINS | Strong pull value per pin |
| pad_slew_slow | output | NPINS | Slow slew per pin |
| pad_filt_en | output | NPINS | Passive filter per pin |
| pad_od_en | output | NPINS | Open drain per pin |
| pad_drive_hi | output | NPINS | High drive per pin |
| pad_mux | output | NPINS*MUX_W | Function select per pin (0 analog/off, 1 GPIO) |
| pad_ibuf_en | output | NPINS | Input buffer enable per pin |
| pad_in_inv | output | NPINS | Input inversion per pin |
| pin_irq_cond | output | NPINS*4 | Interrupt condition code per pin |
| pin_locked | output | NPINS | Lock state per pin |

## Verification
The bench aims at the paths where a write could reach too far. A broadcast whose mask is decoded from the wrong half would configure the wrong pins. A mux-only write built as a full write would wipe the pull and interrupt fields. A lock that covered the whole word would refuse interrupt-code updates, and a lock that broadcasts skip would let a global write unlock a frozen pin. It also probes the unused pull code 1, which a naive decoder would treat as a pull-down. It checks that the lock survives every write path yet clears on reset, and that broadcast and unmapped addresses read back 0 instead of aliasing a pin.

// File: rtl/pcr_bank_pkg.sv
`timescale 1ns/1ps
package pcr_bank_pkg;
    localparam int LO_W         = 16;
    localparam int IRQ_W        = 4;
    localparam int IRQ_LSB      = 16;
    localparam int PULL_LSB     = 0;
    localparam int PULL_VAL_BIT = 2;
    localparam int SLEW_BIT     = 3;
    localparam int FILT_BIT     = 4;
    localparam int OD_BIT       = 5;
    localparam int DRV_BIT      = 6;
    localparam int MUX_LSB      = 8;
    localparam int IBUF_BIT     = 12;
    localparam int INV_BIT      = 13;
    localparam int LOCK_BIT     = 15;

    localparam logic [1:0] PULL_NONE = 2'd0;
    localparam logic [1:0] PULL_DOWN = 2'd2;
    localparam logic [1:0] PULL_UP   = 2'd3;

    // Bits of the lower half that hold a defined field.
    function automatic logic [LO_W-1:0] lo_write_mask(input int mux_w);
        logic [LO_W-1:0] m;
        m = '0;
        for (int b = 0; b <= DRV_BIT; b++) m[b] = 1'b1;
        for (int b = 0; b < mux_w; b++) m[MUX_LSB + b] = 1'b1;
        m[IBUF_BIT] = 1'b1;
        m[INV_BIT]  = 1'b1;
        m[LOCK_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [LO_W-1:0] mux_field_mask(input int mux_w);
        logic [LO_W-1:0] m;
        m = '0;
        for (int b = 0; b < mux_w; b++) m[MUX_LSB + b] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pcr_wr_decode.sv
`timescale 1ns/1ps
module pcr_wr_decode #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [NPINS-1:0]  lo_we,
    output logic [NPINS-1:0]  mux_we,
    output logic [NPINS-1:0]  irq_we
);
    localparam int HALF     = NPINS / 2;
    localparam int A_GLO    = NPINS;
    localparam int A_GHI    = NPINS + 1;
    localparam int A_GIRQLO = NPINS + 2;
    localparam int A_GIRQHI = NPINS + 3;
    localparam int MUX_BASE = 2 * NPINS;

    always_comb begin
        lo_we  = '0;
        mux_we = '0;
        irq_we = '0;
        if (wr) begin
            for (int p = 0; p < NPINS; p++) begin
                if (int'(addr) == p) begin
                    lo_we[p]  = 1'b1;
                    irq_we[p] = 1'b1;
                end
                if (int'(addr) == MUX_BASE + p) mux_we[p] = 1'b1;
            end
            for (int i = 0; i < HALF; i++) begin
                if (int'(addr) == A_GLO    && wdata[16+i]) lo_we[i]        = 1'b1;
                if (int'(addr) == A_GHI    && wdata[16+i]) lo_we[HALF+i]   = 1'b1;
                if (int'(addr) == A_GIRQLO && wdata[i])    irq_we[i]       = 1'b1;
                if (int'(addr) == A_GIRQHI && wdata[i])    irq_we[HALF+i]  = 1'b1;
            end
        end
    end

    // R9: a mux-only access never coincides with a full lower-half write
    p_no_dual_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we & mux_we) == '0);
endmodule

// File: rtl/pcr_pin_cell.sv
`timescale 1ns/1ps
module pcr_pin_cell
    import pcr_bank_pkg::*;
#(
    parameter int MUX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic             mux_we,
    input  logic             irq_we,
    input  logic [LO_W-1:0]  wr_lo,
    input  logic [MUX_W-1:0] wr_mux,
    input  logic [IRQ_W-1:0] wr_irq,
    output logic [31:0]      word
);
    localparam logic [LO_W-1:0] WMASK = lo_write_mask(MUX_W);
    localparam logic [LO_W-1:0] MMASK = mux_field_mask(MUX_W);
    localparam int PAD_W = 32 - IRQ_LSB - IRQ_W;

    logic [LO_W-1:0]  lo_q;
    logic [IRQ_W-1:0] irq_q;
    logic             locked;

    assign locked = lo_q[LOCK_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            irq_q <= '0;
        end else begin
            if (!locked) begin
                if (lo_we)
                    lo_q <= wr_lo & WMASK;
                else if (mux_we)
                    lo_q[MUX_LSB +: MUX_W] <= wr_mux;
            end
            if (irq_we)
                irq_q <= wr_irq;
        end
    end

    assign word = {{PAD_W{1'b0}}, irq_q, lo_q};

    // R5: a locked lower half holds its value across any write
    p_lock_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(lo_q));

    // R5/R8: the interrupt code accepts writes whatever the lock state
    p_irq_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_we |=> (irq_q == $past(wr_irq)));

    // R9: a mux-only update keeps every non-mux bit
    p_mux_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_we && !lo_we) |=> ((lo_q & ~MMASK) == ($past(lo_q) & ~MMASK)));
endmodule

// File: rtl/pcr_bank.sv
`timescale 1ns/1ps
module pcr_bank
    import pcr_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int MUX_W  = 4,
    parameter int ADDR_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NPINS-1:0]        pad_pull_en,
    output logic [NPINS-1:0]        pad_pull_up,
    output logic [NPINS-1:0]        pad_pull_strong,
    output logic [NPINS-1:0]        pad_slew_slow,
    output logic [NPINS-1:0]        pad_filt_en,
    output logic [NPINS-1:0]        pad_od_en,
    output logic [NPINS-1:0]        pad_drive_hi,
    output logic [NPINS*MUX_W-1:0]  pad_mux,
    output logic [NPINS-1:0]        pad_ibuf_en,
    output logic [NPINS-1:0]        pad_in_inv,
    output logic [NPINS*IRQ_W-1:0]  pin_irq_cond,
    output logic [NPINS-1:0]        pin_locked
);
    localparam int MUX_BASE = 2 * NPINS;

    logic [NPINS-1:0] lo_we, mux_we, irq_we;
    logic [31:0]      words [NPINS];

    pcr_wr_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .lo_we  (lo_we),
        .mux_we (mux_we),
        .irq_we (irq_we)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pcr_pin_cell #(.MUX_W(MUX_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .lo_we  (lo_we[p]),
            .mux_we (mux_we[p]),
            .irq_we (irq_we[p]),
            .wr_lo  (bus_wdata[LO_W-1:0]),
            .wr_mux (bus_wdata[MUX_LSB +: MUX_W]),
            .wr_irq (bus_wdata[IRQ_LSB +: IRQ_W]),
            .word   (words[p])
        );

        assign pad_pull_en[p]     = words[p][PULL_LSB+1];
        assign pad_pull_up[p]     = (words[p][PULL_LSB +: 2] == PULL_UP);
        assign pad_pull_strong[p] = words[p][PULL_VAL_BIT];
        assign pad_slew_slow[p]   = words[p][SLEW_BIT];
        assign pad_filt_en[p]     = words[p][FILT_BIT];
        assign pad_od_en[p]       = words[p][OD_BIT];
        assign pad_drive_hi[p]    = words[p][DRV_BIT];
        assign pad_mux[p*MUX_W +: MUX_W]      = words[p][MUX_LSB +: MUX_W];
        assign pad_ibuf_en[p]     = words[p][IBUF_BIT];
        assign pad_in_inv[p]      = words[p][INV_BIT];
        assign pin_irq_cond[p*IRQ_W +: IRQ_W] = words[p][IRQ_LSB +: IRQ_W];
        assign pin_locked[p]      = words[p][LOCK_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (int'(bus_addr) == p || int'(bus_addr) == MUX_BASE + p)
                bus_rdata = words[p];
        end
    end

    // R11: broadcast addresses read back zero
    p_global_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) >= NPINS && int'(bus_addr) < MUX_BASE) |-> (bus_rdata == '0));

    // R12: once set, a lock output stays set until reset
    p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_locked & $past(pin_locked)) == $past(pin_locked));
endmodule

// File: tb/tb_pcr_bank.sv
`timescale 1ns/1ps
module tb_pcr_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS = 32;
    localparam int MUX_W = 4;
    localparam int ADDR_W = 7;
    localparam int NVEC = 12;
    localparam int VW = 7 + 32 + 7 + 32 + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NPINS-1:0] pad_pull_en, pad_pull_up, pad_pull_strong, pad_slew_slow;
    logic [NPINS-1:0] pad_filt_en, pad_od_en, pad_drive_hi, pad_ibuf_en, pad_in_inv, pin_locked;
    logic [NPINS*MUX_W-1:0] pad_mux;
    logic [NPINS*4-1:0] pin_irq_cond;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcr_bank #(.NPINS(NPINS), .MUX_W(MUX_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .pad_pull_strong(pad_pull_strong), .pad_slew_slow(pad_slew_slow),
        .pad_filt_en(pad_filt_en), .pad_od_en(pad_od_en), .pad_drive_hi(pad_drive_hi),
        .pad_mux(pad_mux), .pad_ibuf_en(pad_ibuf_en), .pad_in_inv(pad_in_inv),
        .pin_irq_cond(pin_irq_cond), .pin_locked(pin_locked)
    );

    // {write addr, write data, read addr, expected read, requirement number}
    localparam logic [VW-1:0] VECS [NVEC] = '{
        {7'd3,   32'h000A0103, 7'd3,   32'h000A0103, 8'd2},  // R2 plain store
        {7'd4,   32'hFFF07FFF, 7'd4,   32'h00003F7F, 8'd2},  // R2 undefined bits read 0
        {7'd32,  32'h00090002, 7'd3,   32'h000A0002, 8'd6},  // R6 pins 0,3, irq kept
        {7'd32,  32'h00000123, 7'd0,   32'h00000002, 8'd6},  // R6 empty mask
        {7'd32,  32'h00090005, 7'd1,   32'h00000000, 8'd6},  // R6 unselected pin
        {7'd33,  32'h80010303, 7'd16,  32'h00000303, 8'd7},  // R7 pins 16,31
        {7'd34,  32'h000C0011, 7'd4,   32'h000C3F7F, 8'd8},  // R8 low irq broadcast
        {7'd35,  32'h00058000, 7'd31,  32'h00050303, 8'd8},  // R8 high irq broadcast
        {7'd67,  32'hFFFFFFFF, 7'd3,   32'h000A0F05, 8'd9},  // R9 mux only on pin 3
        {7'd32,  32'h00000000, 7'd32,  32'h00000000, 8'd11}, // R11 broadcast reads 0
        {7'd100, 32'hFFFFFFFF, 7'd100, 32'h00000000, 8'd11}, // R11 unmapped
        {7'd34,  32'h00000000, 7'd0,   32'h000C0005, 8'd8}   // R8 zero mask
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(7'd0, 32'h0, "R1 pin0 word");
        rd_chk(7'd31, 32'h0, "R1 pin31 word");
        chk({31'b0, |{pad_pull_en, pad_pull_up, pad_pull_strong, pad_slew_slow, pad_filt_en,
                      pad_od_en, pad_drive_hi, pad_mux, pad_ibuf_en, pad_in_inv,
                      pin_irq_cond, pin_locked}}, 32'h0, "R1 pad outputs");

        for (int v = 0; v < NVEC; v++) begin
            logic [ADDR_W-1:0] wa, ra;
            logic [31:0] wd, ex;
            logic [7:0] rq;
            {wa, wd, ra, ex, rq} = VECS[v];
            wr(wa, wd);
            rd_chk(ra, ex, $sformatf("R%0d vector %0d", rq, v));
        end

        // R4 every field reaches its pad output (pin 10)
        wr(7'd10, 32'h0009327F);
        chk({22'b0, pad_pull_en[10], pad_pull_up[10], pad_pull_strong[10], pad_slew_slow[10],
             pad_filt_en[10], pad_od_en[10], pad_drive_hi[10], pad_ibuf_en[10],
             pad_in_inv[10], pin_locked[10]}, {22'b0, 10'b1111111110}, "R4 pin10 flags");
        chk({28'b0, pad_mux[10*MUX_W +: MUX_W]}, 32'd2, "R4 pin10 mux");
        chk({28'b0, pin_irq_cond[10*4 +: 4]}, 32'd9, "R4 pin10 irq");

        // R3 pull decode, including unused code 1
        wr(7'd10, 32'h00000001);
        chk({30'b0, pad_pull_en[10], pad_pull_up[10]}, 32'b00, "R3 code1 no pull");
        wr(7'd10, 32'h00000002);
        chk({30'b0, pad_pull_en[10], pad_pull_up[10]}, 32'b10, "R3 code2 pull-down");
        wr(7'd10, 32'h00000003);
        chk({30'b0, pad_pull_en[10], pad_pull_up[10]}, 32'b11, "R3 code3 pull-up");
        wr(7'd10, 32'h00000000);
        chk({30'b0, pad_pull_en[10], pad_pull_up[10]}, 32'b00, "R3 code0 none");

        // R5 lock freezes lower half, irq stays writable
        wr(7'd7, 32'h00008011);
        rd_chk(7'd7, 32'h00008011, "R5 lock set");
        wr(7'd7, 32'h00030000);
        rd_chk(7'd7, 32'h00038011, "R5 lower frozen irq written");
        // R10 mux-only and broadcast writes skip locked pin
        wr(7'd71, 32'h00000F00);
        rd_chk(7'd7, 32'h00038011, "R10 mux window on locked pin");
        wr(7'd32, 32'h00800000);
        rd_chk(7'd7, 32'h00038011, "R10 broadcast on locked pin");
        wr(7'd34, 32'h00060080);
        rd_chk(7'd7, 32'h00068011, "R8 irq broadcast on locked pin");
        chk({31'b0, pin_locked[7]}, 32'd1, "R12 lock held");

        // R12 reset clears the lock
        do_reset();
        rd_chk(7'd7, 32'h0, "R12 reset clears pin7");
        wr(7'd7, 32'h00000002);
        rd_chk(7'd7, 32'h00000002, "R12 pin7 writable after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule